// File: doc/BRIEF.md
# Fractional-Prescaler UART Baud Generator

This block turns one fixed input clock into the two timing strobes a UART needs: a per-sample strobe for the receiver's oversampling and a per-bit strobe for the shifters. The input clock passes through three dividers in series. The first is a fractional prescaler that is set in steps of one eighth. The second is a 16-bit integer divisor. The third is an oversampling counter whose ratio can be set from 4 to 16. The prescaler is an accumulator. It adds 8 on every clock and fires whenever the sum reaches the 9-bit prescaler value. So it divides by value/8 on average, with no more than one clock of jitter on each pulse.

Software programs the block through a small synchronous register port. A control register holds an enhanced-mode enable and a prescaler enable. The prescaler value is split into a low byte and a single high bit. Writing the low byte clears the high bit, so the low byte must be written first. Any register write restarts all three counters, so the first strobe after a write already follows the new settings.

Top module: `fracbaud_gen`

## Requirements
- R1: With effective prescaler P (in eighths), divisor D and ratio N, the k-th `bit_tick` pulse after the last register write comes ceil(k*D*N*P/8) clocks after that write's clock edge, and lasts one clock.
- R2: The j-th `samp_tick` pulse after the last register write comes ceil(j*D*P/8) clocks after that write's clock edge, and lasts one clock.
- R3: The prescaler is a 9-bit value in eighths. Bits 7:0 are at address 2 and bit 8 is bit 0 of address 3. With enhanced mode and the prescaler enable both on, the value is used as written, except that values below 8 act as 8.
- R4: The oversampling ratio is bits 3:0 of address 4. Values 4 to 15 give that ratio, and values 0 to 3 give 16.
- R5: The divisor is bits 7:0 at address 0 and bits 15:8 at address 1. A divisor of 0 divides by 65536.
- R6: The control register is at address 5, and bit 0 of it is the enhanced-mode enable. While that bit is 0, writes to addresses 2 and 3 are ignored, and the effective prescaler is 271 (33.875) whatever the stored value.
- R7: Bit 1 of the control register is the prescaler enable. In enhanced mode, while it is 0, the effective prescaler is 8 (divide by 1).
- R8: An accepted write to address 2 clears prescaler bit 8. Writing address 2 and then address 3 therefore keeps both parts, while the reverse order loses bit 8.
- R9: A register write clears the strobes and all counters at its clock edge. No strobe is high in the cycle after the write edge, even if one was due then.
- R10: `rdata` shows, one clock after `addr` is presented, the register at that address: divisor, prescaler low byte, prescaler high bit, ratio field, and control bits {prescaler enable, enhanced}. Unused addresses read 0. After reset these read 1, 0, 0x0F, 1, 0 and 0.
- R11: `bit_tick` is high only in a cycle where `samp_tick` is also high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fixed input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| samp_tick | output | 1 | One-clock oversampling strobe |
| bit_tick | output | 1 | One-clock per-bit strobe |

## Verification
A register write and a due `bit_tick` can fall on the same clock edge. The restart has to win, with the strobe dropped and the new period counted from that edge. The bench provokes this with a running divide-by-4 setup. It writes the ratio register at exactly the edge where the fourth-cycle tick is due, then checks that both strobes are low after that edge and that the next ticks land 4 and 8 clocks later. A second overlap is a write to the prescaler low byte while enhanced mode is off. Here the write must be discarded while the other registers are untouched; this is judged by reading back both prescaler parts.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int PRE_W  = 9;
    localparam int DIV_W  = 16;
    localparam int OVS_W  = 4;

    localparam logic [ADDR_W-1:0] A_DIV_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_DIV_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_PRE_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_PRE_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_OVS    = 3'd4;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd5;

    localparam int CTRL_ENH_BIT = 0;
    localparam int CTRL_PEN_BIT = 1;

    // prescaler of 1.000 expressed in eighths
    localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(8);
    // reset prescaler 33.875 in eighths
    localparam logic [PRE_W-1:0] PRE_RST = PRE_W'(271);
    localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(1);
    localparam logic [OVS_W-1:0] OVS_MIN = OVS_W'(4);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [PRE_W-1:0]  pre;
        logic [OVS_W-1:0]  ovs;
        logic              enh;
        logic              pen;
        logic [DATA_W-1:0] rdata;
    } regs_t;
endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
    import fbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DIV_W-1:0]  div_lim,
    output logic [PRE_W-1:0]  pre_eff,
    output logic [PRE_W-1:0]  pre_raw,
    output logic [OVS_W-1:0]  ovs_lim,
    output logic              enh
);
    localparam int PRE_HI_W = PRE_W - DATA_W;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (addr)
                A_DIV_LO: r_d.div[DATA_W-1:0] = wdata;
                A_DIV_HI: r_d.div[DIV_W-1:DATA_W] = wdata;
                A_PRE_LO: if (r_q.enh) begin
                    r_d.pre[DATA_W-1:0]     = wdata;
                    r_d.pre[PRE_W-1:DATA_W] = '0;
                end
                A_PRE_HI: if (r_q.enh) r_d.pre[PRE_W-1:DATA_W] = wdata[PRE_HI_W-1:0];
                A_OVS:    r_d.ovs = wdata[OVS_W-1:0];
                A_CTRL: begin
                    r_d.enh = wdata[CTRL_ENH_BIT];
                    r_d.pen = wdata[CTRL_PEN_BIT];
                end
                default: ;
            endcase
        end
        case (addr)
            A_DIV_LO: r_d.rdata = r_q.div[DATA_W-1:0];
            A_DIV_HI: r_d.rdata = r_q.div[DIV_W-1:DATA_W];
            A_PRE_LO: r_d.rdata = r_q.pre[DATA_W-1:0];
            A_PRE_HI: r_d.rdata = {{(DATA_W-PRE_HI_W){1'b0}}, r_q.pre[PRE_W-1:DATA_W]};
            A_OVS:    r_d.rdata = {{(DATA_W-OVS_W){1'b0}}, r_q.ovs};
            A_CTRL:   r_d.rdata = {{(DATA_W-2){1'b0}}, r_q.pen, r_q.enh};
            default:  r_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.div   <= DIV_RST;
            r_q.pre   <= PRE_RST;
            r_q.ovs   <= '0;
            r_q.enh   <= 1'b0;
            r_q.pen   <= 1'b0;
            r_q.rdata <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (!r_q.enh)
            pre_eff = PRE_RST;
        else if (!r_q.pen || (r_q.pre < PRE_ONE))
            pre_eff = PRE_ONE;
        else
            pre_eff = r_q.pre;
        ovs_lim = (r_q.ovs < OVS_MIN) ? '1 : (r_q.ovs - 1'b1);
        div_lim = r_q.div - 1'b1;
    end

    assign rdata   = r_q.rdata;
    assign pre_raw = r_q.pre;
    assign enh     = r_q.enh;
endmodule

// File: rtl/fbg_frac_pre.sv
module fbg_frac_pre #(
    parameter int PW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [PW-1:0] step_div,
    output logic          pulse
);
    localparam int AW = PW + 1;
    localparam logic [AW-1:0] STEP = AW'(8);

    typedef struct packed {
        logic [AW-1:0] acc;
    } fp_t;

    fp_t s_d, s_q;
    logic [AW-1:0] sum;

    always_comb begin
        s_d   = s_q;
        sum   = s_q.acc + STEP;
        pulse = (sum >= {1'b0, step_div});
        if (clr)
            s_d.acc = '0;
        else if (pulse)
            s_d.acc = sum - {1'b0, step_div};
        else
            s_d.acc = sum;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/fbg_cnt.sv
module fbg_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] lim,
    output logic         hit
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cn_t;

    cn_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        hit = en && (s_q.cnt == lim);
        if (clr)
            s_d.cnt = '0;
        else if (hit)
            s_d.cnt = '0;
        else if (en)
            s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/fracbaud_gen.sv
module fracbaud_gen
    import fbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              samp_tick,
    output logic              bit_tick
);
    typedef struct packed {
        logic samp;
        logic baud;
    } out_t;

    logic [DIV_W-1:0] div_lim_w;
    logic [PRE_W-1:0] pre_eff_w;
    logic [PRE_W-1:0] pre_raw_w;
    logic [OVS_W-1:0] ovs_lim_w;
    logic             enh_w;
    logic             pre_pulse;
    logic             samp_hit;
    logic             baud_hit;
    out_t             o_d, o_q;

    fbg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .div_lim (div_lim_w),
        .pre_eff (pre_eff_w),
        .pre_raw (pre_raw_w),
        .ovs_lim (ovs_lim_w),
        .enh     (enh_w)
    );

    fbg_frac_pre #(.PW(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (wr_en),
        .step_div (pre_eff_w),
        .pulse    (pre_pulse)
    );

    fbg_cnt #(.W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_en),
        .en    (pre_pulse),
        .lim   (div_lim_w),
        .hit   (samp_hit)
    );

    fbg_cnt #(.W(OVS_W)) u_ovs (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_en),
        .en    (samp_hit),
        .lim   (ovs_lim_w),
        .hit   (baud_hit)
    );

    always_comb begin
        o_d.samp = samp_hit && !wr_en;
        o_d.baud = baud_hit && !wr_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign samp_tick = o_q.samp;
    assign bit_tick  = o_q.baud;
endmodule

// File: rtl/fbg_chk.sv
module fbg_chk
    import fbg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              samp_tick,
    input logic              bit_tick,
    input logic              enh,
    input logic [PRE_W-1:0]  pre_raw
);
    AST_BIT_WITH_SAMP: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> samp_tick); // R11

    AST_BIT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick); // R4

    AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!samp_tick && !bit_tick)); // R9

    AST_PRE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !enh && ((addr == A_PRE_LO) || (addr == A_PRE_HI))) |=> $stable(pre_raw)); // R6

    AST_LO_CLEARS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && enh && (addr == A_PRE_LO)) |=> !pre_raw[PRE_W-1]); // R8
endmodule

bind fracbaud_gen fbg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .samp_tick (samp_tick),
    .bit_tick  (bit_tick),
    .enh       (enh_w),
    .pre_raw   (pre_raw_w)
);

// File: tb/fracbaud_gen_test.sv
module fracbaud_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 190000;
    localparam int NVEC       = 7;

    // fields: [30] enhanced, [29] prescaler enable, [28:20] prescaler, [19:16] ratio, [15:0] divisor
    localparam logic [30:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 9'd8,   4'd4,  16'd1},
        {1'b1, 1'b1, 9'd500, 4'd0,  16'd2},
        {1'b0, 1'b1, 9'd500, 4'd0,  16'd1},
        {1'b1, 1'b0, 9'd500, 4'd5,  16'd3},
        {1'b1, 1'b1, 9'd3,   4'd2,  16'd1},
        {1'b1, 1'b1, 9'd9,   4'd7,  16'd1},
        {1'b1, 1'b1, 9'd511, 4'd4,  16'd1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       samp_tick;
    logic       bit_tick;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    int    t0 = 0;
    bit    done = 1'b0;
    string vtag [NVEC];

    fracbaud_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .samp_tick (samp_tick),
        .bit_tick  (bit_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!done && cyc > WD_LIMIT) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        t0    = cyc;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        @(posedge clk);
        @(negedge clk);
        v = rdata;
    endtask

    // m8 = D*N*P, s8 = D*P; tick times are ceil(count*m8/8) and ceil(count*s8/8)
    task automatic scan(input string tag, input longint m8, input longint s8,
                        input int nbit, input int nsamp, input int limit);
        int nb;
        int ns;
        nb = 0;
        ns = 0;
        for (int k = 1; k <= limit && (nb < nbit || ns < nsamp); k++) begin
            @(posedge clk);
            @(negedge clk);
            if (samp_tick && ns < nsamp) begin
                ns++;
                chk({tag, " R2 samp time"}, cyc - t0, (ns * s8 + 7) / 8);
            end
            if (bit_tick && nb < nbit) begin
                nb++;
                chk({tag, " R1 bit time"}, cyc - t0, (nb * m8 + 7) / 8);
                chk({tag, " R11 samp with bit"}, samp_tick, 1);
            end
        end
        if (nb < nbit)  chk({tag, " R1 bit count"}, nb, nbit);
        if (ns < nsamp) chk({tag, " R2 samp count"}, ns, nsamp);
    endtask

    function automatic longint peff(bit enh, bit pen, int pre);
        if (!enh) return 271;
        if (!pen || pre < 8) return 8;
        return pre;
    endfunction

    function automatic longint nrat(int o);
        return (o < 4) ? 16 : o;
    endfunction

    function automatic longint dval(int d);
        return (d == 0) ? 65536 : d;
    endfunction

    initial begin
        logic [7:0] v;
        vtag[0] = "R1/R4 ratio4 p1.000";
        vtag[1] = "R3 p62.5 div2";
        vtag[2] = "R6 enhanced off";
        vtag[3] = "R7 bypass";
        vtag[4] = "R3/R4 clamps";
        vtag[5] = "R1 fractional 1.125";
        vtag[6] = "R3 max 63.875";

        repeat (3) @(negedge clk);
        chk("R10 reset samp", samp_tick, 0);
        chk("R10 reset bit", bit_tick, 0);
        rst_n = 1'b1;
        t0 = cyc;
        // reset defaults: P=271, D=1, N=16
        scan("R10 reset default", 16 * 271, 271, 1, 1, 2000);

        rd(3'd0, v); chk("R10 reset div lo", v, 8'h01);
        rd(3'd1, v); chk("R10 reset div hi", v, 8'h00);
        rd(3'd2, v); chk("R10 reset pre lo", v, 8'h0F);
        rd(3'd3, v); chk("R10 reset pre hi", v, 8'h01);
        rd(3'd4, v); chk("R10 reset ratio", v, 8'h00);
        rd(3'd5, v); chk("R10 reset ctrl", v, 8'h00);
        rd(3'd6, v); chk("R10 unused addr", v, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            logic       e;
            logic       p;
            logic [8:0] pr;
            logic [3:0] o;
            logic [15:0] d;
            longint pe;
            longint dd;
            {e, p, pr, o, d} = VEC[i];
            pe = peff(e, p, int'(pr));
            dd = dval(int'(d));
            wr(3'd5, 8'h03);
            wr(3'd2, pr[7:0]);
            wr(3'd3, {7'b0, pr[8]});
            wr(3'd4, {4'b0, o});
            wr(3'd0, d[7:0]);
            wr(3'd1, d[15:8]);
            wr(3'd5, {6'b0, p, e});
            scan(vtag[i], dd * nrat(int'(o)) * pe, dd * pe, 3, 2, 10000);
        end

        rd(3'd4, v); chk("R4 ratio readback", v, 8'h04);
        rd(3'd5, v); chk("R10 ctrl readback", v, 8'h03);

        // R6: prescaler writes ignored with enhanced mode off (stored value is 0x1FF)
        wr(3'd5, 8'h02);
        wr(3'd2, 8'h55);
        wr(3'd3, 8'h00);
        rd(3'd2, v); chk("R6 ignored lo write", v, 8'hFF);
        rd(3'd3, v); chk("R6 ignored hi write", v, 8'h01);

        // R8: write order
        wr(3'd5, 8'h03);
        wr(3'd2, 8'hF4);
        wr(3'd3, 8'h01);
        rd(3'd2, v); chk("R8 right order lo", v, 8'hF4);
        rd(3'd3, v); chk("R8 right order hi", v, 8'h01);
        wr(3'd3, 8'h01);
        wr(3'd2, 8'hF4);
        rd(3'd3, v); chk("R8 wrong order hi cleared", v, 8'h00);

        // R9: write on the edge where a bit tick is due
        wr(3'd2, 8'h08);
        wr(3'd3, 8'h00);
        wr(3'd0, 8'h01);
        wr(3'd1, 8'h00);
        wr(3'd4, 8'h04);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
        addr  = 3'd4;
        wdata = 8'h04;
        wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        t0    = cyc;
        chk("R9 bit dropped at write", bit_tick, 0);
        chk("R9 samp dropped at write", samp_tick, 0);
        scan("R9 restart", 32, 8, 2, 1, 100);

        // R5: divisor 0 acts as 65536
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);
        scan("R5 div zero", 4 * 65536 * 8, 65536 * 8, 0, 1, 70000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule